// File: doc/BRIEF.md
# Clock and Power Mode Controller

This controller follows which clock mode a small microcontroller core is running in, and it decides whether each requested mode change is allowed. It has seven normal operating modes and two sleep modes. The normal modes are medium-speed, high-speed, low-speed, low-power, PLL, on-chip oscillator and on-chip oscillator low-power. The sleep modes are wait and stop.

Inputs arrive from the core as strobes: a WAIT-instruction strobe, an interrupt request, a mode-change request, a stop-bit write and a divide-by-8 bit write. A protect bit and an oscillation-detect enable bit act as qualifiers. The outputs are:
- the current mode
- four oscillator enables
- a CPU clock gate
- the CPU clock divider selection, as a log2 value
- a one-cycle flag raised for every request that has no legal arrow from the current mode

The PLL can only be reached from high-speed mode and can only return to high-speed mode. The PLL may never go straight into a sleep mode.

Top module: `clk_mode_ctrl`

## Requirements
- R1: On reset the controller enters medium-speed mode (code 0). The divide-by-8 bit is 1, so `cpu_div` equals `DIV_LOG`. `cpu_clk_en` is 1, `illegal` is 0 and `osc_en` is 4'b0001.
- R2: The mode codes are 0 medium, 1 high, 2 low, 3 low-power, 4 PLL, 5 on-chip oscillator, 6 on-chip oscillator low-power, 7 wait and 8 stop. `osc_en` is {pll, on-chip, sub, main}. Its value in each normal mode is:
  - 0001 in medium and high
  - 0011 in low
  - 0010 in low-power
  - 1001 in PLL
  - 0101 in on-chip oscillator
  - 0100 in on-chip oscillator low-power
- R3: A mode request (`mode_req_v` with a 3-bit target) moves to the target on the next cycle only if the pair is legal. The legal pairs work in both directions: 0-1, 0-2, 1-2, 2-3, 1-4, 0-5, 1-5, 2-5 and 5-6. A request for the current mode has no effect and raises no flag.
- R4: A refused request leaves the mode, the saved return mode and the divider unchanged, and it sets `illegal` for exactly the next cycle. While `protect_en` is 1, every mode request to a different mode is refused.
- R5: A WAIT strobe in any normal mode other than PLL moves to wait (7) on the next cycle. In wait, `cpu_clk_en` is 0 and `osc_en` keeps the value of the mode that was left.
- R6: A stop write in a permitted normal mode moves to stop (8). In stop, `osc_en` is 0 and `cpu_clk_en` is 0.
- R7: In PLL mode, WAIT strobes, stop writes and requests for any target other than high-speed are all refused.
- R8: A stop write is refused while `osc_det_en` is 1.
- R9: In low-power mode, a stop write is accepted only if `stop_word` is 1 (both control registers written as one word) and `oco_off` is 1.
- R10: An interrupt in wait returns to the saved mode with the divider unchanged. An interrupt in stop returns to the saved mode and forces the divide-by-8 bit to 1.
- R11: An interrupt in the same cycle as a WAIT strobe in a normal mode wins. The mode stays put and no flag is raised.
- R12: In a normal mode, requests are served in this priority order: WAIT strobe first, then stop write, then mode request. A request of lower priority in the same cycle is dropped without a flag. In the sleep modes every input except the interrupt is ignored.
- R13: A divide-by-8 write (`div8_wr`, `div8_val`) takes effect in any normal mode. `cpu_div` is `DIV_LOG` when the bit is 1 and 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_stb | input | 1 | WAIT-instruction strobe |
| irq | input | 1 | Interrupt request |
| mode_req_v | input | 1 | Mode-change request valid |
| mode_req | input | 3 | Target normal-mode code |
| stop_wr | input | 1 | Stop bit written to 1 |
| stop_word | input | 1 | Stop write arrived as a word write of both registers |
| div8_wr | input | 1 | Divide-by-8 bit write strobe |
| div8_val | input | 1 | Divide-by-8 bit write value |
| oco_off | input | 1 | On-chip oscillator turned off |
| protect_en | input | 1 | Clock protection active |
| osc_det_en | input | 1 | Oscillation stop/restart detection enabled |
| mode | output | 4 | Current mode code |
| osc_en | output | 4 | {pll, on-chip, sub, main} enables |
| cpu_clk_en | output | 1 | CPU clock gate |
| cpu_div | output | DIV_W | log2 of CPU clock divisor |
| illegal | output | 1 | Refused-request pulse |

## Verification
The bench builds the block with `DIV_LOG = 2` instead of the default 3. This makes the divided value `cpu_div` differ from the width-derived all-ones pattern, so a hard-coded divisor shows up as a mismatch. The random mix keeps the detection-enable bit high for about a quarter of the cycles and raises the protect bit occasionally. It also covers all eight request targets, including the sleep code 7, which is never legal. Together these reach the refusals, the PLL lockout, the low-power word-write stop entry and the forced divider after stop.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int DIV_LOG = 3,
  localparam int DIV_W = $clog2(DIV_LOG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_stb,
  input  logic             irq,
  input  logic             mode_req_v,
  input  logic [2:0]       mode_req,
  input  logic             stop_wr,
  input  logic             stop_word,
  input  logic             div8_wr,
  input  logic             div8_val,
  input  logic             oco_off,
  input  logic             protect_en,
  input  logic             osc_det_en,
  output logic [3:0]       mode,
  output logic [3:0]       osc_en,
  output logic             cpu_clk_en,
  output logic [DIV_W-1:0] cpu_div,
  output logic             illegal
);
  localparam logic [3:0] M_MED = 4'd0, M_HIGH = 4'd1, M_LOW = 4'd2, M_LPWR = 4'd3,
                         M_PLL = 4'd4, M_OCO = 4'd5, M_OCOLP = 4'd6,
                         M_WAIT = 4'd7, M_STOP = 4'd8;

  function automatic logic arc(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    case ({lo, hi})
      {M_MED, M_HIGH}, {M_MED, M_LOW}, {M_HIGH, M_LOW}, {M_LOW, M_LPWR},
      {M_HIGH, M_PLL}, {M_MED, M_OCO}, {M_HIGH, M_OCO}, {M_LOW, M_OCO},
      {M_OCO, M_OCOLP}: arc = 1'b1;
      default:          arc = 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] osc_of(input logic [3:0] m);
    case (m)
      M_MED, M_HIGH: osc_of = 4'b0001;
      M_LOW:         osc_of = 4'b0011;
      M_LPWR:        osc_of = 4'b0010;
      M_PLL:         osc_of = 4'b1001;
      M_OCO:         osc_of = 4'b0101;
      M_OCOLP:       osc_of = 4'b0100;
      default:       osc_of = 4'b0000;
    endcase
  endfunction

  logic [3:0] mode_q, ret_q, nxt;
  logic       div8_q, ill_q, bad;

  wire        normal  = mode_q < M_WAIT;
  wire [3:0]  tgt     = {1'b0, mode_req};
  wire        stop_ok = (mode_q != M_PLL) && !osc_det_en &&
                        ((mode_q != M_LPWR) || (stop_word && oco_off));

  always_comb begin
    nxt = mode_q;
    bad = 1'b0;
    if (!normal) begin
      if (irq) nxt = ret_q;
    end else if (wait_stb) begin
      if (!irq) begin
        if (mode_q == M_PLL) bad = 1'b1;
        else                 nxt = M_WAIT;
      end
    end else if (stop_wr) begin
      if (stop_ok) nxt = M_STOP;
      else         bad = 1'b1;
    end else if (mode_req_v && tgt != mode_q) begin
      if (!protect_en && arc(mode_q, tgt)) nxt = tgt;
      else                                 bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_MED;
      ret_q  <= M_MED;
      div8_q <= 1'b1;
      ill_q  <= 1'b0;
    end else begin
      mode_q <= nxt;
      ill_q  <= bad;
      if (normal && nxt >= M_WAIT) ret_q <= mode_q;
      if (mode_q == M_STOP && irq) div8_q <= 1'b1;
      else if (normal && div8_wr)  div8_q <= div8_val;
    end
  end

  assign mode       = mode_q;
  assign osc_en     = (mode_q == M_STOP) ? 4'b0000 : osc_of(normal ? mode_q : ret_q);
  assign cpu_clk_en = normal;
  assign cpu_div    = div8_q ? DIV_W'(DIV_LOG) : '0;
  assign illegal    = ill_q;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk #(
  parameter int DIV_LOG = 3,
  localparam int DIV_W = $clog2(DIV_LOG + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_stb,
  input logic             irq,
  input logic             mode_req_v,
  input logic [2:0]       mode_req,
  input logic             stop_wr,
  input logic             stop_word,
  input logic             div8_wr,
  input logic             div8_val,
  input logic             oco_off,
  input logic             protect_en,
  input logic             osc_det_en,
  input logic [3:0]       mode,
  input logic [3:0]       osc_en,
  input logic             cpu_clk_en,
  input logic [DIV_W-1:0] cpu_div,
  input logic             illegal
);
  p_reset_state_r1: assert property (@(posedge clk) $rose(rst_n) |-> (mode == 4'd0 && cpu_div == DIV_W'(DIV_LOG)));
  p_illegal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> $stable(mode));
  p_wait_gated_r5: assert property (@(posedge clk) disable iff (!rst_n) (mode == 4'd7) |-> (!cpu_clk_en && osc_en != 4'b0000));
  p_stop_dark_r6: assert property (@(posedge clk) disable iff (!rst_n) (mode == 4'd8) |-> (!cpu_clk_en && osc_en == 4'b0000));
  p_pll_no_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n) (mode == 4'd4) |=> (mode == 4'd4 || mode == 4'd1));
  p_pll_entry_r7: assert property (@(posedge clk) disable iff (!rst_n) (mode != 4'd4 && mode != 4'd1) |=> (mode != 4'd4));
  p_stop_detect_r8: assert property (@(posedge clk) disable iff (!rst_n) (mode != 4'd8 && osc_det_en) |=> (mode != 4'd8));
  p_stop_exit_div_r10: assert property (@(posedge clk) disable iff (!rst_n) (mode == 4'd8 && irq) |=> (cpu_div == DIV_W'(DIV_LOG) && mode != 4'd8));
  p_irq_beats_wait_r11: assert property (@(posedge clk) disable iff (!rst_n) (mode < 4'd7 && wait_stb && irq) |=> ($stable(mode) && !illegal));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk #(.DIV_LOG(DIV_LOG)) u_chk (.*);

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_LOG = 2;
  localparam int DIV_W = $clog2(DIV_LOG + 1);

  logic clk = 0, rst_n = 0;
  logic wait_stb, irq, mode_req_v, stop_wr, stop_word, div8_wr, div8_val, oco_off, protect_en, osc_det_en;
  logic [2:0] mode_req;
  logic [3:0] mode, osc_en;
  logic cpu_clk_en, illegal;
  logic [DIV_W-1:0] cpu_div;
  int checks = 0, failures = 0;

  logic [3:0] e_mode, e_ret;
  logic e_div8, e_ill;
  string why;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl #(.DIV_LOG(DIV_LOG)) u_clk_mode_ctrl (.*);

  function automatic bit legal_pair(input int a, input int b);
    int lo = a < b ? a : b;
    int hi = a < b ? b : a;
    return (lo==0&&hi==1)||(lo==0&&hi==2)||(lo==1&&hi==2)||(lo==2&&hi==3)||(lo==1&&hi==4)||
           (lo==0&&hi==5)||(lo==1&&hi==5)||(lo==2&&hi==5)||(lo==5&&hi==6);
  endfunction

  function automatic logic [3:0] osc_for(input logic [3:0] m);
    case (m)
      0, 1: return 4'b0001;
      2: return 4'b0011;
      3: return 4'b0010;
      4: return 4'b1001;
      5: return 4'b0101;
      6: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_next();
    logic [3:0] n = e_mode;
    logic b = 0;
    why = "R12";
    if (e_mode >= 7) begin
      if (irq) begin
        n = e_ret; why = "R10";
        if (e_mode == 8) e_div8 = 1;
      end
    end else begin
      if (div8_wr) e_div8 = div8_val;
      if (wait_stb) begin
        if (irq) why = "R11";
        else if (e_mode == 4) begin b = 1; why = "R7"; end
        else begin n = 7; why = "R5"; end
      end else if (stop_wr) begin
        if (e_mode == 4) begin b = 1; why = "R7"; end
        else if (osc_det_en) begin b = 1; why = "R8"; end
        else if (e_mode == 3 && !(stop_word && oco_off)) begin b = 1; why = "R9"; end
        else begin n = 8; why = "R6"; end
      end else if (mode_req_v && {1'b0, mode_req} != e_mode) begin
        if (protect_en || !legal_pair(e_mode, mode_req)) begin b = 1; why = "R4"; end
        else begin n = {1'b0, mode_req}; why = "R3"; end
      end
      if (n >= 7) e_ret = e_mode;
    end
    e_mode = n;
    e_ill = b;
  endtask

  task automatic check_all();
    check(why, mode, e_mode);
    check("R2", osc_en, e_mode == 8 ? 0 : osc_for(e_mode == 7 ? e_ret : e_mode));
    check("R5", cpu_clk_en, e_mode < 7);
    check("R13", cpu_div, e_div8 ? DIV_LOG : 0);
    check({why, " illegal"}, illegal, e_ill);
  endtask

  task automatic clr();
    {wait_stb, irq, mode_req_v, stop_wr, stop_word, div8_wr, div8_val, oco_off, protect_en, osc_det_en} = '0;
    mode_req = 0;
  endtask

  task automatic step();
    model_next();
    @(negedge clk);
    check_all();
  endtask

  task automatic req(input int m);
    clr(); mode_req_v = 1; mode_req = 3'(m); step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    e_mode = 0; e_ret = 0; e_div8 = 1; e_ill = 0;
    @(negedge clk);
    check("R1 mode", mode, 0);
    check("R1 div", cpu_div, DIV_LOG);
    check("R1 osc", osc_en, 4'b0001);
    check("R1 clk", cpu_clk_en, 1);
    check("R1 illegal", illegal, 0);

    req(1); req(4);
    check("R7 in pll", mode, 4);
    clr(); wait_stb = 1; step();
    check("R7 wait refused", illegal, 1);
    clr(); stop_wr = 1; step();
    check("R7 stop refused", mode, 4);
    req(0);
    check("R7 exit only high", mode, 4);
    req(1);
    clr(); wait_stb = 1; irq = 1; step();
    check("R11 irq wins", mode, 1);
    clr(); wait_stb = 1; step();
    check("R5 wait osc", osc_en, 4'b0001);
    clr(); irq = 1; step();
    check("R10 wait exit", mode, 1);
    clr(); div8_wr = 1; div8_val = 0; step();
    clr(); stop_wr = 1; osc_det_en = 1; step();
    check("R8 detect blocks stop", mode, 1);
    clr(); stop_wr = 1; step();
    clr(); irq = 1; step();
    check("R10 stop exit div8", cpu_div, DIV_LOG);
    req(2); req(3);
    clr(); stop_wr = 1; stop_word = 0; oco_off = 1; step();
    check("R9 byte write refused", mode, 3);
    clr(); stop_wr = 1; stop_word = 1; oco_off = 1; step();
    check("R9 word stop", mode, 8);
    clr(); irq = 1; step();
    clr(); mode_req_v = 1; mode_req = 2; protect_en = 1; step();
    check("R4 protect", mode, 3);
    clr(); step();
    check("R4 one-cycle pulse", illegal, 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      clr();
      wait_stb   = ($urandom % 10) == 0;
      irq        = ($urandom % 5) == 0;
      mode_req_v = ($urandom % 10) < 3;
      mode_req   = 3'($urandom % 8);
      stop_wr    = ($urandom % 10) == 0;
      stop_word  = $urandom % 2;
      oco_off    = $urandom % 2;
      div8_wr    = ($urandom % 10) == 0;
      div8_val   = $urandom % 2;
      protect_en = ($urandom % 10) == 0;
      osc_det_en = ($urandom % 4) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule